// File: doc/BRIEF.md
# Read/Write Latency Data-Window Scheduler

This block sits behind the command path of a double-data-rate memory controller. Each accepted READ or WRITE command yields a cycle-accurate window. A read opens the window in which returning data is valid. A write opens the window in which the controller must drive data. Read latency is the sum of the posted additive latency and the CAS latency. Write latency is one clock less than read latency. Two beats move per clock, one on each edge, so a burst of four spans two clocks and a burst of eight spans four.

Latency and burst length are sampled with each command, and the command then waits in a per-direction token pipeline until its window opens. Because of this, back-to-back commands and commands issued under different settings each land at their own time. A command of the same direction that opens while a burst is still running replaces what is left of that burst. Inside a window the block reports which beat falls on the rising edge and which on the falling edge. Strobe phase alignment and pad drivers are handled elsewhere. The outputs are clock-level control only.

Top module: `lat_sched`

## Requirements
- R1: While reset is held low and after its release with no command, rdValid and wrEnable are 0 and all four beat outputs are 0.
- R2: A read (cmdValid=1, cmdIsWrite=0) sampled at rising edge k makes rdValid 1 in the cycles following edges k+AL+CL through k+AL+CL+N-1. N is 2 when burstLen8=0 (four beats) and 4 when burstLen8=1 (eight beats).
- R3: A write (cmdValid=1, cmdIsWrite=1) sampled at edge k makes wrEnable 1 in the cycles following edges k+AL+CL-1 through k+AL+CL-1+N-1, with N as in R2.
- R4: In the n-th clock of a window (n counted from 0), the rising-edge beat output is 2n and the falling-edge beat output is 2n+1. Outside a window both outputs are 0.
- R5: When a same-direction window opens while an earlier one is still running, the earlier one ends. The beats restart at 0, and the window length follows the new command's burst length.
- R6: casLat, addLat and burstLen8 are captured per command. Changing them after a command is accepted does not move or resize that command's window.
- R7: Commands of one direction issued every two clocks with four-beat bursts give an unbroken window with beats 0..3 repeating.
- R8: The read and write windows are independent, and both can be open in the same cycle with their own beat numbers.
- R9: A casLat value below 2 behaves exactly as casLat=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | A command is accepted at this edge |
| cmdIsWrite | input | 1 | 1 = write, 0 = read |
| casLat | input | 3 | CAS latency in clocks (values below 2 act as 2) |
| addLat | input | 3 | Posted additive latency in clocks |
| burstLen8 | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| rdValid | output | 1 | Read data window open |
| rdBeatRise | output | 3 | Read beat number on the rising edge |
| rdBeatFall | output | 3 | Read beat number on the falling edge |
| wrEnable | output | 1 | Write data window open |
| wrBeatRise | output | 3 | Write beat number on the rising edge |
| wrBeatFall | output | 3 | Write beat number on the falling edge |

## Verification
Two functions can fall on the same cycle: a pending token reaching the head of its pipeline, and a running burst reaching its last clock or any middle clock. In that cycle the new window has to take over, with beats back at 0. The bench provokes this with two eight-beat reads two clocks apart. Reads every two clocks make the new window open exactly as the old one would close, and constrained-random traffic with latencies changing per command makes starts collide and run out of order. A bench model is driven only by the recorded start cycles and burst lengths. Every cycle it predicts the valid flag and both beat numbers for each direction, and these are compared against the outputs.

// File: rtl/lat_sched_pkg.sv
package lat_sched_pkg;

  localparam int NUM_LANES = 2;
  localparam int LANE_RD = 0;
  localparam int LANE_WR = 1;

  typedef struct packed {
    logic [NUM_LANES-1:0] start;
    logic [NUM_LANES-1:0] bl8;
  } ctrlStrobes_t;

endpackage

// File: rtl/lat_sched_ctrl.sv
module lat_sched_ctrl
  import lat_sched_pkg::*;
#(
  parameter int CL_W   = 3,
  parameter int AL_W   = 3,
  parameter int MIN_CL = 2,
  parameter int DEPTH  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic            cmdIsWrite,
  input  logic [CL_W-1:0] casLat,
  input  logic [AL_W-1:0] addLat,
  input  logic            burstLen8,
  output ctrlStrobes_t    strobes
);

  localparam int LAT_W = $clog2(DEPTH + 1);

  logic [LAT_W-1:0] effCl;
  logic [LAT_W-1:0] readLat;
  logic [LAT_W-1:0] writeLat;
  logic [NUM_LANES-1:0] laneStart;
  logic [NUM_LANES-1:0] laneBl8;

  always_comb begin
    effCl    = (LAT_W'(casLat) < LAT_W'(MIN_CL)) ? LAT_W'(MIN_CL) : LAT_W'(casLat);
    readLat  = effCl + LAT_W'(addLat);
    writeLat = readLat - LAT_W'(1);
  end

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    logic [DEPTH-1:0] tokValid;
    logic [DEPTH-1:0] tokBl8;
    logic [DEPTH-1:0] insMask;
    logic [DEPTH-1:0] shiftValid;
    logic [DEPTH-1:0] shiftBl8;
    logic [LAT_W-1:0] laneLat;
    logic             laneIns;

    always_comb begin
      laneLat    = (lane == LANE_WR) ? writeLat : readLat;
      laneIns    = cmdValid && (cmdIsWrite == (lane == LANE_WR));
      insMask    = laneIns ? (DEPTH'(1) << (laneLat - LAT_W'(1))) : '0;
      shiftValid = {1'b0, tokValid[DEPTH-1:1]};
      shiftBl8   = {1'b0, tokBl8[DEPTH-1:1]};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tokValid <= '0;
        tokBl8   <= '0;
      end else begin
        tokValid <= shiftValid | insMask;
        tokBl8   <= (shiftBl8 & ~insMask) | (insMask & {DEPTH{burstLen8}});
      end
    end

    assign laneStart[lane] = tokValid[0];
    assign laneBl8[lane]   = tokBl8[0];
  end

  assign strobes.start = laneStart;
  assign strobes.bl8   = laneBl8;

  // R9: shortest read (clamped CAS, no additive) reaches the head two edges on
  p_min_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdIsWrite && readLat == LAT_W'(MIN_CL)) |=> ##1 strobes.start[LANE_RD]);

  // R3: a write is one clock earlier than the matching read
  p_write_early_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIsWrite && readLat == LAT_W'(MIN_CL)) |=> strobes.start[LANE_WR]);

endmodule

// File: rtl/lat_sched_lane.sv
module lat_sched_lane #(
  parameter int MAX_BURST = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               startBl8,
  output logic               winValid,
  output logic [$clog2(MAX_BURST)-1:0] beatRise,
  output logic [$clog2(MAX_BURST)-1:0] beatFall
);

  localparam int BEAT_W    = $clog2(MAX_BURST);
  localparam int CLK_W     = BEAT_W - 1;
  localparam int LAST_LONG = MAX_BURST / 2 - 1;
  localparam int LAST_SHRT = MAX_BURST / 4 - 1;

  logic             active;
  logic             bl8Cur;
  logic [CLK_W-1:0] clkIdx;
  logic             atLast;

  assign atLast = (clkIdx == (bl8Cur ? CLK_W'(LAST_LONG) : CLK_W'(LAST_SHRT)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bl8Cur <= 1'b0;
      clkIdx <= '0;
    end else if (start) begin
      active <= 1'b1;
      bl8Cur <= startBl8;
      clkIdx <= '0;
    end else if (active) begin
      if (atLast) begin
        active <= 1'b0;
        clkIdx <= '0;
      end else begin
        clkIdx <= clkIdx + CLK_W'(1);
      end
    end
  end

  assign winValid = active;
  assign beatRise = active ? {clkIdx, 1'b0} : '0;
  assign beatFall = active ? {clkIdx, 1'b1} : '0;

  // R5: a start always opens a fresh window at beat 0
  p_start_opens_r5: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (winValid && beatRise == '0));

  // R2: a window closes after its last clock unless restarted
  p_window_close_r2: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !start && atLast) |=> !winValid);

  // R4: beats advance by two per clock within a window
  p_beat_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !start && !atLast) |=> (winValid && beatRise == $past(beatRise) + BEAT_W'(2)));

endmodule

// File: rtl/lat_sched_beats.sv
module lat_sched_beats
  import lat_sched_pkg::*;
#(
  parameter int MAX_BURST = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  output logic [NUM_LANES-1:0] winValid,
  output logic [NUM_LANES-1:0][$clog2(MAX_BURST)-1:0] beatRise,
  output logic [NUM_LANES-1:0][$clog2(MAX_BURST)-1:0] beatFall
);

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    lat_sched_lane #(.MAX_BURST(MAX_BURST)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .start    (strobes.start[lane]),
      .startBl8 (strobes.bl8[lane]),
      .winValid (winValid[lane]),
      .beatRise (beatRise[lane]),
      .beatFall (beatFall[lane])
    );
  end

endmodule

// File: rtl/lat_sched.sv
module lat_sched
  import lat_sched_pkg::*;
#(
  parameter int CL_W      = 3,
  parameter int AL_W      = 3,
  parameter int MIN_CL    = 2,
  parameter int DEPTH     = 16,
  parameter int MAX_BURST = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic                         cmdIsWrite,
  input  logic [CL_W-1:0]              casLat,
  input  logic [AL_W-1:0]              addLat,
  input  logic                         burstLen8,
  output logic                         rdValid,
  output logic [$clog2(MAX_BURST)-1:0] rdBeatRise,
  output logic [$clog2(MAX_BURST)-1:0] rdBeatFall,
  output logic                         wrEnable,
  output logic [$clog2(MAX_BURST)-1:0] wrBeatRise,
  output logic [$clog2(MAX_BURST)-1:0] wrBeatFall
);

  localparam int BEAT_W = $clog2(MAX_BURST);

  ctrlStrobes_t strobes;
  logic [NUM_LANES-1:0]             winValid;
  logic [NUM_LANES-1:0][BEAT_W-1:0] beatRise;
  logic [NUM_LANES-1:0][BEAT_W-1:0] beatFall;

  lat_sched_ctrl #(
    .CL_W(CL_W), .AL_W(AL_W), .MIN_CL(MIN_CL), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdIsWrite (cmdIsWrite),
    .casLat     (casLat),
    .addLat     (addLat),
    .burstLen8  (burstLen8),
    .strobes    (strobes)
  );

  lat_sched_beats #(.MAX_BURST(MAX_BURST)) u_beats (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .winValid (winValid),
    .beatRise (beatRise),
    .beatFall (beatFall)
  );

  assign rdValid    = winValid[LANE_RD];
  assign rdBeatRise = beatRise[LANE_RD];
  assign rdBeatFall = beatFall[LANE_RD];
  assign wrEnable   = winValid[LANE_WR];
  assign wrBeatRise = beatRise[LANE_WR];
  assign wrBeatFall = beatFall[LANE_WR];

endmodule

// File: tb/lat_sched_tb.sv
module lat_sched_tb;

  localparam int HIST = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdIsWrite = 1'b0;
  logic [2:0] casLat = 3'd5;
  logic [2:0] addLat = 3'd0;
  logic burstLen8 = 1'b0;
  logic rdValid, wrEnable;
  logic [2:0] rdBeatRise, rdBeatFall, wrBeatRise, wrBeatFall;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string curReq = "R2";

  bit pend [2][HIST];
  bit pendBl [2][HIST];
  bit mAct [2];
  int mIdx [2];
  int mLen [2];

  lat_sched u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsWrite(cmdIsWrite),
    .casLat(casLat), .addLat(addLat), .burstLen8(burstLen8),
    .rdValid(rdValid), .rdBeatRise(rdBeatRise), .rdBeatFall(rdBeatFall),
    .wrEnable(wrEnable), .wrBeatRise(wrBeatRise), .wrBeatFall(wrBeatFall)
  );

  always #5 clk = ~clk;

  // reference model: advances after each rising edge from recorded starts
  always @(posedge clk) begin
    cyc = cyc + 1;
    for (int l = 0; l < 2; l++) begin
      if (!rstN) begin
        mAct[l] = 1'b0; mIdx[l] = 0; mLen[l] = 0;
      end else if (cyc < HIST && pend[l][cyc]) begin
        mAct[l] = 1'b1; mIdx[l] = 0; mLen[l] = pendBl[l][cyc] ? 4 : 2;
      end else if (mAct[l]) begin
        mIdx[l] = mIdx[l] + 1;
        if (mIdx[l] == mLen[l]) begin
          mAct[l] = 1'b0; mIdx[l] = 0;
        end
      end
    end
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && cyc > 0) begin
      int expR, expW;
      expR = mAct[0] ? {1'b1, 3'(2*mIdx[0]), 3'(2*mIdx[0]+1)} : 0;
      expW = mAct[1] ? {1'b1, 3'(2*mIdx[1]), 3'(2*mIdx[1]+1)} : 0;
      check(curReq, "read {valid,rise,fall}", {rdValid, rdBeatRise, rdBeatFall}, expR);
      check(curReq, "write {valid,rise,fall}", {wrEnable, wrBeatRise, wrBeatFall}, expW);
    end
  end

  // called at a negedge; command is sampled at the next rising edge
  task automatic issue(bit isWr, int cl, int al, bit bl8);
    int eff, lat, k;
    cmdValid = 1'b1; cmdIsWrite = isWr;
    casLat = 3'(cl); addLat = 3'(al); burstLen8 = bl8;
    eff = (cl < 2) ? 2 : cl;
    lat = eff + al - (isWr ? 1 : 0);
    k = cyc + 1;
    if (k + lat < HIST) begin
      pend[isWr][k + lat] = 1'b1;
      pendBl[isWr][k + lat] = bl8;
    end
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "rdValid in reset", int'(rdValid), 0);
    check("R1", "wrEnable in reset", int'(wrEnable), 0);
    check("R1", "beats in reset", {rdBeatRise, rdBeatFall, wrBeatRise, wrBeatFall}, 0);
    rstN = 1'b1;
    curReq = "R1"; idle(4);

    curReq = "R2"; issue(0, 5, 0, 0); idle(12);
    issue(0, 6, 3, 1); idle(16);

    curReq = "R3"; issue(1, 6, 2, 1); idle(14);
    issue(1, 2, 0, 0); idle(8);

    curReq = "R4"; issue(0, 4, 1, 1); idle(12);

    curReq = "R5"; issue(0, 5, 0, 1); idle(1); issue(0, 5, 0, 1); idle(14);
    issue(1, 5, 1, 1); idle(2); issue(1, 5, 1, 0); idle(14);

    curReq = "R6"; issue(0, 7, 0, 1); issue(0, 3, 0, 0);
    casLat = 3'd2; addLat = 3'd0; burstLen8 = 1'b0; idle(16);

    curReq = "R7";
    for (int i = 0; i < 6; i++) begin issue(0, 5, 1, 0); idle(1); end
    idle(12);

    curReq = "R8"; issue(0, 5, 0, 1); issue(1, 5, 0, 1); idle(14);

    curReq = "R9"; issue(0, 1, 0, 0); idle(6); issue(0, 0, 0, 1); idle(8);
    issue(1, 0, 0, 0); idle(8);

    curReq = "R5";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(2) == 0)
        issue(1'($urandom_range(1)), $urandom_range(7), $urandom_range(7), 1'($urandom_range(1)));
      else
        idle(1);
    end
    idle(24);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule